// File: doc/BRIEF.md
# Conditional Near Branch Unit

This block resolves near control transfers for a 16-bit instruction pointer. A request carries a transfer kind, a 4-bit condition code, the five arithmetic flags (overflow, carry, zero, sign, parity), the current and next-instruction pointers, a signed displacement and the two candidate operands of an indirect jump. One clock later the block reports the new pointer value. It also reports whether the transfer was taken, whether a general-protection fault was raised, and whether the prefetch queue must be flushed.

A conditional branch and a relative jump compute their target by adding the sign-extended displacement to the current pointer. An indirect jump takes its target from a register operand or a memory word. In protected mode the chosen target is compared against the code segment limit. A target above the limit raises the fault, and the pointer stays where it was. Instruction fetch, operand reads and flag generation are done elsewhere.

Top module: `nbr_unit`

## Requirements
- R1: During and right after reset, `res_valid`, `taken`, `gp_fault` and `flush` are 0 and `new_ip` is 0.
- R2: With `req_kind` = 0 (conditional), the even condition codes test: 0 overflow, 2 carry, 4 zero, 6 carry or zero, 8 sign, 10 parity, 12 sign differs from overflow, 14 zero or (sign differs from overflow).
- R3: Each odd condition code (code with bit 0 set) yields the exact inverse of the even code one below it.
- R4: For `req_kind` 0 (when the condition is true) and 1 (unconditional relative), the target is `cur_ip + disp`, with `disp` two's complement, taken modulo 65536.
- R5: For `req_kind` 2 or 3 (indirect), the target is `ind_reg` when `ind_mod` equals 3 and `ind_mem` otherwise.
- R6: With `prot_mode` = 1, a wanted transfer whose target is strictly greater than `cs_limit` (unsigned) gives `gp_fault` = 1, `taken` = 0, `flush` = 0 and `new_ip` = `cur_ip`. A target equal to the limit does not fault.
- R7: With `prot_mode` = 0, no limit comparison is made and no fault is raised.
- R8: A taken transfer sets `taken` = 1 and `flush` = 1 in the same result cycle, with `new_ip` = target.
- R9: A conditional branch whose condition is false gives `new_ip` = `next_ip`, with `taken`, `flush` and `gp_fault` all 0. No limit fault can arise from it.
- R10: Results appear with `res_valid` = 1 exactly one clock after `req_valid` is sampled high, back-to-back requests included. `taken` and `gp_fault` are never both 1.
- R11: In a cycle with no result, `taken`, `flush` and `gp_fault` are 0 and `new_ip` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 conditional, 1 relative jump, 2/3 indirect jump |
| cond_code | input | 4 | Condition selector |
| flag_of | input | 1 | Overflow flag |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_pf | input | 1 | Parity flag |
| cur_ip | input | 16 | Pointer the displacement is added to |
| next_ip | input | 16 | Fall-through pointer |
| disp | input | 16 | Signed displacement |
| ind_mod | input | 2 | Addressing mode field; 3 means register operand |
| ind_reg | input | 16 | Register operand of an indirect jump |
| ind_mem | input | 16 | Memory word operand of an indirect jump |
| prot_mode | input | 1 | Protected mode enable |
| cs_limit | input | 16 | Code segment limit |
| res_valid | output | 1 | Result strobe |
| new_ip | output | 16 | Resulting instruction pointer |
| taken | output | 1 | Transfer taken |
| gp_fault | output | 1 | General-protection fault, error code 0 |
| flush | output | 1 | Prefetch flush pulse |

## Verification
The condition decode and the limit check can both act on one request. A true condition may still be cancelled by a fault, and a false condition must mask a target that would otherwise fault. The bench provokes both cases. It sends conditional branches in protected mode whose computed target lies above the limit, once with the condition true and once with it false. It expects a fault with the pointer held in the first case, and a clean fall-through in the second. It also sets the target exactly at the limit and one above it, and wraps the addition through zero so that a wrapped target is compared in its truncated form.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  typedef struct packed {
    logic ovf;
    logic cry;
    logic zro;
    logic sgn;
    logic par;
  } nbr_flags_t;

  localparam logic [1:0] MOD_REGISTER = 2'b11;

  // even-code condition; bit 0 of the code inverts it
  function automatic logic cond_even(input logic [2:0] sel, input nbr_flags_t f);
    logic lt;
    lt = f.sgn ^ f.ovf;
    case (sel)
      3'd0: cond_even = f.ovf;
      3'd1: cond_even = f.cry;
      3'd2: cond_even = f.zro;
      3'd3: cond_even = f.cry | f.zro;
      3'd4: cond_even = f.sgn;
      3'd5: cond_even = f.par;
      3'd6: cond_even = lt;
      default: cond_even = f.zro | lt;
    endcase
  endfunction
endpackage

// File: rtl/nbr_cond_eval.sv
module nbr_cond_eval
  import nbr_pkg::*;
(
  input  logic [3:0] code_i,
  input  nbr_flags_t flags_i,
  output logic       true_o
);
  logic base_w;
  always_comb begin
    base_w = cond_even(code_i[3:1], flags_i);
    true_o = base_w ^ code_i[0];
  end
endmodule

// File: rtl/nbr_target_gen.sv
module nbr_target_gen
  import nbr_pkg::*;
#(
  parameter int IP_W = 16
) (
  input  logic            is_ind_i,
  input  logic [1:0]      mod_i,
  input  logic [IP_W-1:0] cur_ip_i,
  input  logic [IP_W-1:0] disp_i,
  input  logic [IP_W-1:0] ind_reg_i,
  input  logic [IP_W-1:0] ind_mem_i,
  output logic [IP_W-1:0] target_o
);
  localparam int SUM_W = IP_W + 1;

  function automatic logic [IP_W-1:0] wrap_add(input logic [IP_W-1:0] a,
                                               input logic [IP_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = {1'b0, a} + {b[IP_W-1], b};
    wrap_add = s[IP_W-1:0];
  endfunction

  logic [IP_W-1:0] rel_w;
  logic [IP_W-1:0] ind_w;

  always_comb begin
    rel_w    = wrap_add(cur_ip_i, disp_i);
    ind_w    = (mod_i == MOD_REGISTER) ? ind_reg_i : ind_mem_i;
    target_o = is_ind_i ? ind_w : rel_w;
  end
endmodule

// File: rtl/nbr_limit_chk.sv
module nbr_limit_chk #(
  parameter int IP_W = 16
) (
  input  logic            prot_i,
  input  logic [IP_W-1:0] target_i,
  input  logic [IP_W-1:0] limit_i,
  output logic            over_o
);
  always_comb over_o = prot_i && (target_i > limit_i);
endmodule

// File: rtl/nbr_unit.sv
module nbr_unit
  import nbr_pkg::*;
#(
  parameter int IP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [3:0]      cond_code,
  input  logic            flag_of,
  input  logic            flag_cf,
  input  logic            flag_zf,
  input  logic            flag_sf,
  input  logic            flag_pf,
  input  logic [IP_W-1:0] cur_ip,
  input  logic [IP_W-1:0] next_ip,
  input  logic [IP_W-1:0] disp,
  input  logic [1:0]      ind_mod,
  input  logic [IP_W-1:0] ind_reg,
  input  logic [IP_W-1:0] ind_mem,
  input  logic            prot_mode,
  input  logic [IP_W-1:0] cs_limit,
  output logic            res_valid,
  output logic [IP_W-1:0] new_ip,
  output logic            taken,
  output logic            gp_fault,
  output logic            flush
);
  nbr_flags_t      flags_w;
  logic            cond_true_w;
  logic            want_w;
  logic            is_ind_w;
  logic [IP_W-1:0] target_w;
  logic            over_w;
  logic            take_w;
  logic            fault_w;
  logic [IP_W-1:0] ip_next_w;

  always_comb begin
    flags_w = '{ovf: flag_of, cry: flag_cf, zro: flag_zf, sgn: flag_sf, par: flag_pf};
    is_ind_w = req_kind[1];
  end

  nbr_cond_eval u_cond (
    .code_i (cond_code),
    .flags_i(flags_w),
    .true_o (cond_true_w)
  );

  nbr_target_gen #(.IP_W(IP_W)) u_tgt (
    .is_ind_i (is_ind_w),
    .mod_i    (ind_mod),
    .cur_ip_i (cur_ip),
    .disp_i   (disp),
    .ind_reg_i(ind_reg),
    .ind_mem_i(ind_mem),
    .target_o (target_w)
  );

  nbr_limit_chk #(.IP_W(IP_W)) u_lim (
    .prot_i  (prot_mode),
    .target_i(target_w),
    .limit_i (cs_limit),
    .over_o  (over_w)
  );

  always_comb begin
    want_w  = (req_kind != 2'd0) || cond_true_w;
    fault_w = want_w && over_w;
    take_w  = want_w && !over_w;
    if (fault_w)     ip_next_w = cur_ip;
    else if (take_w) ip_next_w = target_w;
    else             ip_next_w = next_ip;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      new_ip    <= '0;
      taken     <= 1'b0;
      gp_fault  <= 1'b0;
      flush     <= 1'b0;
    end else begin
      res_valid <= req_valid;
      taken     <= req_valid && take_w;
      gp_fault  <= req_valid && fault_w;
      flush     <= req_valid && take_w;
      if (req_valid) new_ip <= ip_next_w;
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken && gp_fault));
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r8_flush_taken: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> flush);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!taken && !flush && !gp_fault));
  a_r7_real_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_mode) |=> !gp_fault);
  a_r6_fault_holds_ip: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fault_w) |=> (new_ip == $past(cur_ip)));
  a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && !cond_true_w) |=> (new_ip == $past(next_ip) && !taken && !gp_fault));
endmodule

// File: tb/nbr_unit_tb.sv
module nbr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [3:0]  cond_code = '0;
  logic        flag_of = 0, flag_cf = 0, flag_zf = 0, flag_sf = 0, flag_pf = 0;
  logic [15:0] cur_ip = '0, next_ip = '0, disp = '0, ind_reg = '0, ind_mem = '0, cs_limit = '0;
  logic [1:0]  ind_mod = '0;
  logic        prot_mode = 1'b0;
  logic        res_valid, taken, gp_fault, flush;
  logic [15:0] new_ip;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] ip;
    logic        tk;
    logic        gp;
    string       req;
  } exp_t;
  exp_t sb[$];
  logic [15:0] last_ip = '0;
  bit done_run = 0;

  always #10 clk = ~clk;

  nbr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .cond_code(cond_code), .flag_of(flag_of), .flag_cf(flag_cf), .flag_zf(flag_zf),
    .flag_sf(flag_sf), .flag_pf(flag_pf), .cur_ip(cur_ip), .next_ip(next_ip),
    .disp(disp), .ind_mod(ind_mod), .ind_reg(ind_reg), .ind_mem(ind_mem),
    .prot_mode(prot_mode), .cs_limit(cs_limit), .res_valid(res_valid),
    .new_ip(new_ip), .taken(taken), .gp_fault(gp_fault), .flush(flush)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // full 16-entry model written out independently
  function automatic logic ref_cond(input logic [3:0] c, input logic o, input logic ca,
                                    input logic z, input logic s, input logic p);
    case (c)
      4'h0: return o;            4'h1: return !o;
      4'h2: return ca;           4'h3: return !ca;
      4'h4: return z;            4'h5: return !z;
      4'h6: return ca || z;      4'h7: return !ca && !z;
      4'h8: return s;            4'h9: return !s;
      4'hA: return p;            4'hB: return !p;
      4'hC: return s != o;       4'hD: return s == o;
      4'hE: return z || (s != o);
      default: return (s == o) && !z;
    endcase
  endfunction

  task automatic send(input logic [1:0] k, input logic [3:0] c, input logic [4:0] fl,
                      input logic [15:0] cip, input logic [15:0] nip, input logic [15:0] d,
                      input logic [1:0] md, input logic [15:0] rg, input logic [15:0] mm,
                      input logic pm, input logic [15:0] lim, input string req);
    exp_t e;
    logic want;
    logic [15:0] tgt;
    @(negedge clk);
    req_valid = 1; req_kind = k; cond_code = c;
    {flag_of, flag_cf, flag_zf, flag_sf, flag_pf} = fl;
    cur_ip = cip; next_ip = nip; disp = d; ind_mod = md; ind_reg = rg; ind_mem = mm;
    prot_mode = pm; cs_limit = lim;
    want = (k == 2'd0) ? ref_cond(c, fl[4], fl[3], fl[2], fl[1], fl[0]) : 1'b1;
    tgt = (k >= 2'd2) ? ((md == 2'd3) ? rg : mm) : 16'((32'(cip) + 32'(d)) % 65536);
    e.req = req;
    if (!want) begin e.ip = nip; e.tk = 0; e.gp = 0; end
    else if (pm && (tgt > lim)) begin e.ip = cip; e.tk = 0; e.gp = 1; end
    else begin e.ip = tgt; e.tk = 1; e.gp = 0; end
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  // monitor: compare results as they come out
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done_run) begin
        if (res_valid) begin
          if (sb.size() == 0) begin
            check("R10", 1, 0, "unexpected result");
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, new_ip, e.ip, "new_ip");
            check(e.req, taken, e.tk, "taken");
            check(e.req, gp_fault, e.gp, "gp_fault");
            check(e.req == "R9" ? "R9" : "R8", flush, e.tk, "flush");
            last_ip = e.ip;
          end
        end else begin
          check("R11", {taken, flush, gp_fault}, 0, "idle pulses");
          check("R11", new_ip, last_ip, "new_ip held");
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {res_valid, taken, gp_fault, flush}, 0, "reset pulses");
    check("R1", new_ip, 0, "reset ip");
    rst_n = 1;
    // R2 / R3: every code under several flag patterns, real mode
    for (int f = 0; f < 32; f += 7) begin
      for (int c = 0; c < 16; c++) begin
        send(2'd0, 4'(c), 5'(f), 16'h1000, 16'h1003, 16'h0040, 2'd0, 0, 0, 0, 0,
             (c % 2 == 1) ? "R3" : "R2");
      end
    end
    for (int f = 0; f < 32; f++)
      send(2'd0, 4'hE, 5'(f), 16'h2000, 16'h2002, 16'hFFF0, 0, 0, 0, 0, 0, "R2");
    // R4: wrap forward and backward
    send(2'd1, 0, 0, 16'hFFF0, 16'hFFF3, 16'h0020, 0, 0, 0, 0, 0, "R4");
    send(2'd1, 0, 0, 16'h0005, 16'h0008, 16'hFFF0, 0, 0, 0, 0, 0, "R4");
    // R5: indirect register vs memory
    send(2'd2, 0, 0, 16'h0100, 16'h0102, 0, 2'd3, 16'hAAAA, 16'h5555, 0, 0, "R5");
    send(2'd3, 0, 0, 16'h0100, 16'h0102, 0, 2'd1, 16'hAAAA, 16'h5555, 0, 0, "R5");
    // R6: limit boundary in protected mode
    send(2'd1, 0, 0, 16'h0100, 16'h0103, 16'h0100, 0, 0, 0, 1, 16'h0200, "R6");
    send(2'd1, 0, 0, 16'h0100, 16'h0103, 16'h0101, 0, 0, 0, 1, 16'h0200, "R6");
    send(2'd2, 0, 0, 16'h0300, 16'h0302, 0, 2'd3, 16'h9000, 0, 1, 16'h8FFF, "R6");
    // R6 with wrapped target compared truncated
    send(2'd1, 0, 0, 16'hFFF0, 16'hFFF3, 16'h0020, 0, 0, 0, 1, 16'h0010, "R6");
    // R7: same over-limit target in real mode
    send(2'd1, 0, 0, 16'h0100, 16'h0103, 16'h0101, 0, 0, 0, 0, 16'h0200, "R7");
    // R6/R9 overlap: condition true faults, condition false falls through
    send(2'd0, 4'h4, 5'b00100, 16'h0100, 16'h0102, 16'h7000, 0, 0, 0, 1, 16'h0400, "R6");
    send(2'd0, 4'h5, 5'b00100, 16'h0100, 16'h0102, 16'h7000, 0, 0, 0, 1, 16'h0400, "R9");
    idle(4);
    // R10: spaced request after idle
    send(2'd1, 0, 0, 16'h4000, 16'h4003, 16'h0010, 0, 0, 0, 0, 0, "R10");
    idle(4);
    check("R10", sb.size(), 0, "all results seen");
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule